// File: doc/BRIEF.md
# Banked GPIO Interrupt Router

This block gathers the pending interrupt requests of one bank of GPIO ports and steers them onto a small set of interrupt lines. Each port holds one route mask for each line. A pin raises a line when the pin is pending and its bit is set in that port's mask for the line. A single pin may therefore drive any subset of the lines at the same time. The block does not detect triggers itself: a per-pin edge or level detector upstream supplies the pending vector.

Software reaches the block through a single-beat register interface with two windows. The port window holds read-only status words, one per port and line. Each status word shows which pins of the port are pending and routed to that line. The security window holds the route masks and a control word with a write-lock bit and a read-lock bit. A secure requester can always program the routing. A non-secure requester can program it only while both lock bits are clear, and it reads the masks as zero while the read lock is set. Every request gets a response exactly one cycle later.

Top module: `irqr_bank`

## Requirements
- R1: After reset the control word reads zero, `irq_o` is zero, and every port's mask for line 0 holds ones across that port's pin count while all other masks are zero. With the default parameters the pin counts of ports 0 to 7 are 7, 8, 6, 8, 3, 8, 5, 8.
- R2: `irq_o[x]` is registered. One cycle after `pend_i` and the masks settle, it equals the OR over all ports of (pending bits of the port AND the port's mask for line x). With no pending bits, every line is low on the next cycle.
- R3: A read in the port window (`req_win`=0) at port*0x200 + 0x100 + line*4 returns, in its low bits, the port's pending bits ANDed with its mask for that line, as sampled in the request cycle.
- R4: A secure write in the security window (`req_win`=1) at 0x814 + port*0x20 + line*4 stores data bits [PINS-1:0] as that mask, with bits at or above the port's pin count forced to zero. Pending bits above the pin count therefore never raise a line.
- R5: A non-secure route mask write takes effect only while control bit 28 (write lock) and control bit 27 (read lock) are both clear. Otherwise it is dropped.
- R6: While control bit 27 is set, a non-secure route mask read returns zero. Secure reads, and all reads while bit 27 is clear, return the stored mask.
- R7: The control word sits at 0x80C in the security window. Only a secure write changes it, and only bits 28 and 27 are kept. A non-secure write to it is ignored.
- R8: Unaligned addresses, addresses that decode to no register, and control or route offsets presented in the port window read as zero and leave all state unchanged when written.
- R9: `rsp_valid` is high exactly in the cycle after each cycle in which `req_valid` is high. A write's response carries zero data.
- R10: A pin routed to several lines raises all of those lines in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Register request strobe, one beat |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Requester is secure |
| req_win | input | 1 | 0 = port window, 1 = security window |
| req_addr | input | 12 | Byte offset inside the selected window |
| req_wdata | input | 32 | Write data |
| pend_i | input | NUM_PORTS*PINS | Pending requests, port p in bits [p*PINS +: PINS] |
| irq_o | output | NUM_LINES | Registered interrupt lines |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |

## Verification
A register read's data is due one clock after the request edge. The bench drives each request on a falling edge, queues the expected word at that time, and lets a monitor pop and compare on the next falling edge, the first one after the capturing rising edge. A mask write lands on the edge that captures it, so `irq_o` reflects it one edge later. A change on `pend_i` reaches `irq_o` after one edge. Each line check therefore waits one further falling edge after the last stimulus before it compares against a model built from the stored mask copy and the pin counts.

// File: rtl/irqr_pkg.sv
package irqr_pkg;

  localparam logic [11:0] CTRL_OFS   = 12'h80C;
  localparam logic [11:0] ROUTE_BASE = 12'h814;
  localparam int          WLOCK_BIT  = 28;
  localparam int          RLOCK_BIT  = 27;

  // pin count per port, 4 bits each, port 0 in the low nibble
  localparam logic [31:0] DEF_PORT_PINS = {4'd8, 4'd5, 4'd8, 4'd3, 4'd8, 4'd6, 4'd8, 4'd7};

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_CTRL   = 2'd1,
    ACC_ROUTE  = 2'd2,
    ACC_STATUS = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [2:0] port;
    logic [2:0] line;
  } acc_dec_t;

  function automatic acc_dec_t decode_addr(input logic win, input logic [11:0] a,
                                           input int np, input int nl);
    acc_dec_t   d;
    logic [11:0] off;
    d.kind = ACC_NONE;
    d.port = '0;
    d.line = '0;
    off    = a - ROUTE_BASE;
    if (a[1:0] == 2'b00) begin
      if (win) begin
        if (a == CTRL_OFS) begin
          d.kind = ACC_CTRL;
        end else if (a >= ROUTE_BASE && int'(off) < np * 32 && int'(off[4:2]) < nl) begin
          d.kind = ACC_ROUTE;
          d.port = off[7:5];
          d.line = off[4:2];
        end
      end else if (a[8:5] == 4'b1000 && int'(a[11:9]) < np && int'(a[4:2]) < nl) begin
        d.kind = ACC_STATUS;
        d.port = a[11:9];
        d.line = a[4:2];
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/irqr_route_store.sv
module irqr_route_store
  import irqr_pkg::*;
#(
  parameter int          NUM_PORTS = 8,
  parameter int          NUM_LINES = 8,
  parameter int          PINS      = 8,
  parameter logic [31:0] PORT_PINS = DEF_PORT_PINS
) (
  input  logic clk,
  input  logic rst,
  input  logic req_secure,
  input  logic wr_req,
  input  logic [2:0] wr_port,
  input  logic [2:0] wr_line,
  input  logic [PINS-1:0] wr_data,
  input  logic ctrl_req,
  input  logic [31:0] ctrl_wdata,
  output logic [NUM_PORTS-1:0][NUM_LINES-1:0][PINS-1:0] masks,
  output logic wlock,
  output logic rlock
);

  logic [NUM_PORTS-1:0][PINS-1:0] impl;
  logic accept;

  // a non-secure requester may only program while both locks are clear
  assign accept = wr_req && (req_secure || !(wlock || rlock));

  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam int CNT = int'(PORT_PINS[p*4 +: 4]);
      assign impl[p] = (CNT >= PINS) ? '1 : PINS'((1 << CNT) - 1);
      for (genvar x = 0; x < NUM_LINES; x++) begin : g_line
        always_ff @(posedge clk) begin
          if (rst) begin
            masks[p][x] <= (x == 0) ? impl[p] : '0;
          end else if (accept && wr_port == 3'(p) && wr_line == 3'(x)) begin
            masks[p][x] <= wr_data & impl[p];
          end
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      wlock <= 1'b0;
      rlock <= 1'b0;
    end else if (ctrl_req && req_secure) begin
      wlock <= ctrl_wdata[WLOCK_BIT];
      rlock <= ctrl_wdata[RLOCK_BIT];
    end
  end

  p_lock_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !req_secure && (wlock || rlock)) |=> $stable(masks));

  p_ns_ctrl_ignored_r7: assert property (@(posedge clk) disable iff (rst)
    (ctrl_req && !req_secure) |=> ($stable(wlock) && $stable(rlock)));

endmodule

// File: rtl/irqr_line_reduce.sv
module irqr_line_reduce #(
  parameter int NUM_PORTS = 8,
  parameter int NUM_LINES = 8,
  parameter int PINS      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic [NUM_PORTS-1:0][PINS-1:0] pend,
  input  logic [NUM_PORTS-1:0][NUM_LINES-1:0][PINS-1:0] masks,
  output logic [NUM_LINES-1:0] irq_o
);

  logic [NUM_LINES-1:0] any_hit;

  always_comb begin
    any_hit = '0;
    for (int x = 0; x < NUM_LINES; x++) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        any_hit[x] = any_hit[x] | (|(pend[p] & masks[p][x]));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= any_hit;
  end

  p_quiet_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (pend == '0) |=> (irq_o == '0));

endmodule

// File: rtl/irqr_readback.sv
module irqr_readback
  import irqr_pkg::*;
#(
  parameter int NUM_PORTS = 8,
  parameter int NUM_LINES = 8,
  parameter int PINS      = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_secure,
  input  acc_dec_t dec,
  input  logic wlock,
  input  logic rlock,
  input  logic [NUM_PORTS-1:0][PINS-1:0] pend,
  input  logic [NUM_PORTS-1:0][NUM_LINES-1:0][PINS-1:0] masks,
  output logic rsp_valid,
  output logic [31:0] rsp_rdata
);

  logic [31:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (!req_write) begin
      case (dec.kind)
        ACC_CTRL: begin
          rd_next[WLOCK_BIT] = wlock;
          rd_next[RLOCK_BIT] = rlock;
        end
        ACC_ROUTE: begin
          if (req_secure || !rlock) rd_next[PINS-1:0] = masks[dec.port][dec.line];
        end
        ACC_STATUS: rd_next[PINS-1:0] = pend[dec.port] & masks[dec.port][dec.line];
        default: rd_next = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_next : '0;
    end
  end

endmodule

// File: rtl/irqr_bank.sv
module irqr_bank
  import irqr_pkg::*;
#(
  parameter int          NUM_PORTS = 8,
  parameter int          NUM_LINES = 8,
  parameter int          PINS      = 8,
  parameter logic [31:0] PORT_PINS = DEF_PORT_PINS
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_write,
  input  logic req_secure,
  input  logic req_win,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [NUM_PORTS*PINS-1:0] pend_i,
  output logic [NUM_LINES-1:0] irq_o,
  output logic rsp_valid,
  output logic [31:0] rsp_rdata
);

  acc_dec_t dec;
  logic [NUM_PORTS-1:0][PINS-1:0] pend;
  logic [NUM_PORTS-1:0][NUM_LINES-1:0][PINS-1:0] masks;
  logic wlock, rlock;
  logic wr_req, ctrl_req;

  assign pend     = pend_i;
  assign dec      = decode_addr(req_win, req_addr, NUM_PORTS, NUM_LINES);
  assign wr_req   = req_valid && req_write && dec.kind == ACC_ROUTE;
  assign ctrl_req = req_valid && req_write && dec.kind == ACC_CTRL;

  irqr_route_store #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES), .PINS(PINS), .PORT_PINS(PORT_PINS)
  ) u_store (
    .clk(clk), .rst(rst), .req_secure(req_secure),
    .wr_req(wr_req), .wr_port(dec.port), .wr_line(dec.line),
    .wr_data(req_wdata[PINS-1:0]),
    .ctrl_req(ctrl_req), .ctrl_wdata(req_wdata),
    .masks(masks), .wlock(wlock), .rlock(rlock)
  );

  irqr_line_reduce #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES), .PINS(PINS)
  ) u_reduce (
    .clk(clk), .rst(rst), .pend(pend), .masks(masks), .irq_o(irq_o)
  );

  irqr_readback #(
    .NUM_PORTS(NUM_PORTS), .NUM_LINES(NUM_LINES), .PINS(PINS)
  ) u_read (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .dec(dec), .wlock(wlock), .rlock(rlock),
    .pend(pend), .masks(masks), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  p_no_stray_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  p_rdlock_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !req_secure && dec.kind == ACC_ROUTE && rlock)
      |=> (rsp_rdata == '0));

endmodule

// File: tb/sim_irqr_bank.sv
`timescale 1ns/1ps
module sim_irqr_bank;
  localparam int NP = 8;
  localparam int NL = 8;
  localparam int PN = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0, req_win = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [NP*PN-1:0] pend = '0;
  logic [NL-1:0] irq;
  logic rsp_valid;
  logic [31:0] rsp_rdata;

  irqr_bank u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_secure(req_secure), .req_win(req_win), .req_addr(req_addr),
    .req_wdata(req_wdata), .pend_i(pend), .irq_o(irq),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int total = 0, bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  int pins_of[NP] = '{7, 8, 6, 8, 3, 8, 5, 8};
  logic [7:0] mdl[NP][NL];
  logic m_wl = 1'b0, m_rl = 1'b0;

  function automatic logic [7:0] impl(int p);
    return (pins_of[p] >= 8) ? 8'hFF : 8'((1 << pins_of[p]) - 1);
  endfunction

  function automatic logic [11:0] ra(int p, int x);
    return 12'(32'h814 + p * 32 + x * 4);
  endfunction

  function automatic logic [11:0] sa(int p, int x);
    return 12'(p * 512 + 256 + x * 4);
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one beat, expected response queued for the monitor
  task automatic bus(logic win, logic sec, logic wr, logic [11:0] a,
                     logic [31:0] d, logic [31:0] exp, string tag);
    req_valid = 1'b1; req_win = win; req_secure = sec; req_write = wr;
    req_addr = a; req_wdata = d;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic route_wr(logic sec, int p, int x, logic [31:0] d, string tag);
    if (sec || !(m_wl || m_rl)) mdl[p][x] = d[7:0] & impl(p);
    bus(1'b1, sec, 1'b1, ra(p, x), d, 32'h0, tag);
  endtask

  task automatic route_rd(logic sec, int p, int x, string tag);
    logic [31:0] e;
    e = (sec || !m_rl) ? {24'h0, mdl[p][x]} : 32'h0;
    bus(1'b1, sec, 1'b0, ra(p, x), 32'h0, e, tag);
  endtask

  task automatic stat_rd(int p, int x, string tag);
    logic [31:0] e;
    e = {24'h0, pend[p*8 +: 8] & mdl[p][x]};
    bus(1'b0, 1'b0, 1'b0, sa(p, x), 32'h0, e, tag);
  endtask

  task automatic ctrl_wr(logic sec, logic [31:0] d);
    if (sec) begin m_wl = d[28]; m_rl = d[27]; end
    bus(1'b1, sec, 1'b1, 12'h80C, d, 32'h0, "R7 ctrl write response");
  endtask

  task automatic ctrl_rd(string tag);
    logic [31:0] e;
    e = 32'h0; e[28] = m_wl; e[27] = m_rl;
    bus(1'b1, 1'b0, 1'b0, 12'h80C, 32'h0, e, tag);
  endtask

  task automatic irq_chk(string tag);
    logic [7:0] e;
    @(negedge clk);
    e = '0;
    for (int x = 0; x < NL; x++)
      for (int p = 0; p < NP; p++)
        if ((pend[p*8 +: 8] & mdl[p][x]) != 8'h0) e[x] = 1'b1;
    chk(tag, {24'h0, irq}, {24'h0, e});
  endtask

  // monitor
  always @(negedge clk) begin : mon
    string t;
    logic [31:0] e;
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R9 unexpected response: actual=1 expected=0");
      end else begin
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        chk(t, rsp_rdata, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R9 watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++)
      for (int x = 0; x < NL; x++)
        mdl[p][x] = (x == 0) ? impl(p) : 8'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {24'h0, irq}, 32'h0);
    ctrl_rd("R1 ctrl after reset");
    for (int p = 0; p < NP; p++) route_rd(1'b1, p, 0, "R1 default line0 mask");
    route_rd(1'b1, 3, 3, "R1 other mask zero");

    // R2: single pin on default route
    pend[1*8 + 2] = 1'b1;
    irq_chk("R2 single pin to line0");
    stat_rd(1, 0, "R3 status port1 line0");
    stat_rd(1, 1, "R3 status port1 line1 unrouted");

    // R5 unlocked non-secure write accepted, R10 fan-out
    route_wr(1'b0, 1, 5, 32'h04, "R5 ns write unlocked");
    route_rd(1'b0, 1, 5, "R5 ns write unlocked readback");
    irq_chk("R10 pin on line0 and line5");

    // R4 secure write truncated to pin count
    route_wr(1'b1, 4, 2, 32'hFF, "R4 secure write");
    route_rd(1'b1, 4, 2, "R4 mask trimmed to 3 pins");
    pend[4*8 +: 8] = 8'hFF;
    irq_chk("R2 two ports several lines");
    stat_rd(4, 2, "R3 status port4 line2");

    // R4 pending above pin count never fires
    pend = '0;
    irq_chk("R2 idle lines low");
    pend[0*8 + 7] = 1'b1;
    irq_chk("R4 pin above count ignored");
    stat_rd(0, 0, "R4 status above count");

    // R7 control access
    ctrl_wr(1'b0, 32'h1000_0000);
    ctrl_rd("R7 ns ctrl write ignored");
    ctrl_wr(1'b1, 32'hFFFF_FFFF);
    ctrl_rd("R7 only lock bits kept");

    // both locks
    route_wr(1'b0, 2, 1, 32'h3F, "R5 ns write both locks");
    route_rd(1'b0, 2, 1, "R6 ns read while read-locked");
    route_rd(1'b1, 2, 1, "R5 locked write dropped");
    route_wr(1'b1, 2, 1, 32'h15, "R4 secure write while locked");
    route_rd(1'b1, 2, 1, "R4 secure write while locked readback");

    // write lock only
    ctrl_wr(1'b1, 32'h1000_0000);
    route_rd(1'b0, 2, 1, "R6 ns read allowed without read lock");
    route_wr(1'b0, 2, 1, 32'h01, "R5 ns write under write lock");
    route_rd(1'b1, 2, 1, "R5 write lock drops ns write");

    // read lock only
    ctrl_wr(1'b1, 32'h0800_0000);
    route_wr(1'b0, 2, 1, 32'h02, "R5 ns write under read lock");
    route_rd(1'b1, 2, 1, "R5 read lock drops ns write");

    // unlocked again
    ctrl_wr(1'b1, 32'h0);
    route_wr(1'b0, 2, 1, 32'h0A, "R5 ns write after unlock");
    route_rd(1'b0, 2, 1, "R5 ns write after unlock readback");
    pend[2*8 + 3] = 1'b1;
    irq_chk("R10 port2 pin3 on line1");
    stat_rd(2, 1, "R3 status port2 line1");

    // R8 unmapped and unaligned
    bus(1'b1, 1'b1, 1'b1, 12'h815, 32'h0, 32'h0, "R8 unaligned write response");
    route_rd(1'b1, 0, 0, "R8 unaligned write left mask");
    bus(1'b1, 1'b1, 1'b0, 12'h810, 32'h0, 32'h0, "R8 hole in security window");
    bus(1'b0, 1'b1, 1'b0, 12'h120, 32'h0, 32'h0, "R8 hole in port window");
    bus(1'b0, 1'b1, 1'b0, 12'h80C, 32'h0, 32'h0, "R8 ctrl offset in port window");
    bus(1'b0, 1'b1, 1'b1, 12'h80C, 32'h1800_0000, 32'h0, "R8 write in port window");
    ctrl_rd("R8 ctrl unchanged by port window write");

    @(negedge clk);
    chk("R9 every request answered", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule